// File: doc/BRIEF.md
# Push-Button Debouncer with Tick-Divided Sampling

This block turns the bouncing level of a mechanical push-button into a clean signal. A timebase strobe arrives every 2 ms. The block counts these strobes and takes one sample of the button on every fifth strobe, so the button is sampled every 10 ms. The raw button first passes through a two-flop synchronizer. Each sample then advances a four-state machine: idle, press validation, held, and release validation.

A new button level is accepted only after three consecutive samples show it, which is at least 20 ms of stable input. When a press is accepted, the debounced level rises and a single-cycle press pulse is raised in the same clock cycle. The release is validated the same way before the machine returns to idle and can accept a new press. A failed validation returns the machine to the state it came from.

Top module: `key_debounce`

## Requirements
- R1: While `rstN` is low, `debLevel` and `pressPulse` are 0. After reset the tick divider restarts, so the first sample is taken on the fifth tick after reset.
- R2: The button is sampled only on the clock edge where `tickIn` is high for the fifth time since the last sample, or since reset. Button activity at any other time has no effect, and `debLevel` changes only on such an edge.
- R3: In the idle state, low samples leave `debLevel` at 0 and `pressPulse` at 0.
- R4: On the third consecutive high sample, `debLevel` becomes 1 and `pressPulse` is 1 on the same clock edge.
- R5: A low sample after one or two high samples returns the machine to idle. `debLevel` stays 0, and a later press again needs three consecutive high samples.
- R6: `pressPulse` is high for exactly one clock cycle, once per accepted press, and is not repeated while the button stays held.
- R7: From the held state, three consecutive low samples clear `debLevel` to 0 without a `pressPulse`.
- R8: A high sample during release validation returns the machine to the held state. `debLevel` stays 1, and a release again needs three consecutive low samples.
- R9: `rawBtn` passes through two synchronizer flops. A change that arrives on the clock edge of a sample is not seen by that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickIn | input | 1 | One-cycle timebase strobe, one every 2 ms |
| rawBtn | input | 1 | Raw, bouncing button level (1 = pressed) |
| debLevel | output | 1 | Debounced button level |
| pressPulse | output | 1 | One-cycle pulse when a press is accepted |

## Verification
A button held high with no ticks, and then held through 14 and 15 ticks, separates a correct divide-by-five from a divider with the wrong ratio and from a sampler that ignores the tick. Press patterns of high-high-low and release patterns of low-low-high show that each failed validation restarts the count and returns to the right state, not to an intermediate one. Pulses that rise and fall between samples, and a level change applied on the same edge as a sample, separate a correct two-flop synchronizer and sample-only evaluation from a design that looks at the button continuously. A reset while the button is held checks that both the output and the divider phase return to their start values.

// File: rtl/kdb_pkg.sv
package kdb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RISE = 2'd1,
    ST_HELD = 2'd2,
    ST_FALL = 2'd3
  } dbState_t;

  typedef struct packed {
    logic sampleEn;
    logic sampleBit;
  } sampleInfo_t;

  typedef struct packed {
    logic setDeb;
    logic clrDeb;
    logic firePress;
  } ctrlStrobe_t;

endpackage

// File: rtl/kdb_datapath.sv
module kdb_datapath
  import kdb_pkg::*;
#(
  parameter int TICKS_PER_SAMPLE = 5,
  parameter int SYNC_STAGES      = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickIn,
  input  logic        rawBtn,
  input  ctrlStrobe_t strobe,
  output sampleInfo_t sample,
  output logic        debLevel,
  output logic        pressPulse
);

  localparam int CNT_W = (TICKS_PER_SAMPLE > 1) ? $clog2(TICKS_PER_SAMPLE) : 1;
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(TICKS_PER_SAMPLE - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0]       tickCnt;
  logic                   tickWrap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rawBtn};
  end

  assign tickWrap = tickIn && (tickCnt == LAST_TICK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         tickCnt <= '0;
    else if (tickWrap) tickCnt <= '0;
    else if (tickIn)   tickCnt <= tickCnt + 1'b1;
  end

  assign sample.sampleEn  = tickWrap;
  assign sample.sampleBit = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      debLevel   <= 1'b0;
      pressPulse <= 1'b0;
    end else begin
      pressPulse <= strobe.firePress;
      if (strobe.setDeb)      debLevel <= 1'b1;
      else if (strobe.clrDeb) debLevel <= 1'b0;
    end
  end

endmodule

// File: rtl/kdb_control.sv
module kdb_control
  import kdb_pkg::*;
#(
  parameter int CONFIRM_SAMPLES = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  sampleInfo_t sample,
  output ctrlStrobe_t strobe
);

  localparam int RUN_W = $clog2(CONFIRM_SAMPLES + 1);
  localparam logic [RUN_W-1:0] LAST_RUN = RUN_W'(CONFIRM_SAMPLES - 1);

  dbState_t         state, stateNxt;
  logic [RUN_W-1:0] runCnt, runCntNxt;

  always_comb begin
    stateNxt  = state;
    runCntNxt = runCnt;
    strobe    = '0;
    if (sample.sampleEn) begin
      unique case (state)
        ST_IDLE: if (sample.sampleBit) begin
          stateNxt  = ST_RISE;
          runCntNxt = RUN_W'(1);
        end
        ST_RISE: begin
          if (!sample.sampleBit) begin
            stateNxt = ST_IDLE;
          end else if (runCnt == LAST_RUN) begin
            stateNxt         = ST_HELD;
            strobe.setDeb    = 1'b1;
            strobe.firePress = 1'b1;
          end else begin
            runCntNxt = runCnt + 1'b1;
          end
        end
        ST_HELD: if (!sample.sampleBit) begin
          stateNxt  = ST_FALL;
          runCntNxt = RUN_W'(1);
        end
        ST_FALL: begin
          if (sample.sampleBit) begin
            stateNxt = ST_HELD;
          end else if (runCnt == LAST_RUN) begin
            stateNxt      = ST_IDLE;
            strobe.clrDeb = 1'b1;
          end else begin
            runCntNxt = runCnt + 1'b1;
          end
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      runCnt <= '0;
    end else begin
      state  <= stateNxt;
      runCnt <= runCntNxt;
    end
  end

endmodule

// File: rtl/key_debounce.sv
module key_debounce
  import kdb_pkg::*;
#(
  parameter int TICKS_PER_SAMPLE = 5,
  parameter int CONFIRM_SAMPLES  = 3,
  parameter int SYNC_STAGES      = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickIn,
  input  logic rawBtn,
  output logic debLevel,
  output logic pressPulse
);

  sampleInfo_t sample;
  ctrlStrobe_t strobe;

  kdb_datapath #(
    .TICKS_PER_SAMPLE(TICKS_PER_SAMPLE),
    .SYNC_STAGES     (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .tickIn    (tickIn),
    .rawBtn    (rawBtn),
    .strobe    (strobe),
    .sample    (sample),
    .debLevel  (debLevel),
    .pressPulse(pressPulse)
  );

  kdb_control #(
    .CONFIRM_SAMPLES(CONFIRM_SAMPLES)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .sample(sample),
    .strobe(strobe)
  );

endmodule

// File: rtl/kdb_checker.sv
module kdb_checker (
  input logic clk,
  input logic rstN,
  input logic tickIn,
  input logic debLevel,
  input logic pressPulse
);

  AST_RESET_CLEARS: assert property (@(posedge clk) !rstN |=> (!debLevel && !pressPulse)); // R1
  AST_DEB_ON_TICK: assert property (@(posedge clk) disable iff (!rstN) !$stable(debLevel) |-> $past(tickIn)); // R2
  AST_PRESS_RAISES: assert property (@(posedge clk) disable iff (!rstN) pressPulse |-> (debLevel && !$past(debLevel))); // R4
  AST_PRESS_SINGLE: assert property (@(posedge clk) disable iff (!rstN) pressPulse |=> !pressPulse); // R6
  AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rstN) $fell(debLevel) |-> !pressPulse); // R7

endmodule

bind key_debounce kdb_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .tickIn    (tickIn),
  .debLevel  (debLevel),
  .pressPulse(pressPulse)
);

// File: tb/key_debounce_bench.sv
`timescale 1ns/1ps
module key_debounce_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickIn = 1'b0;
  logic rawBtn = 1'b0;
  logic debLevel, pressPulse;
  int   nCompared = 0;
  int   nMismatched = 0;
  bit   finished = 1'b0;

  always #2.5 clk = ~clk;

  key_debounce u_key_debounce (
    .clk       (clk),
    .rstN      (rstN),
    .tickIn    (tickIn),
    .rawBtn    (rawBtn),
    .debLevel  (debLevel),
    .pressPulse(pressPulse)
  );

  task automatic check(input string req, input logic act, input logic exp, input string what);
    nCompared++;
    if (act !== exp) begin
      nMismatched++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic doTick();
    @(negedge clk) tickIn = 1'b1;
    @(negedge clk) tickIn = 1'b0;
  endtask

  // one full sample period: level settles, then five ticks; returns just after the sampling edge
  task automatic takeSample(input logic v);
    @(negedge clk) rawBtn = v;
    repeat (3) @(negedge clk);
    repeat (5) doTick();
  endtask

  task automatic releaseFully();
    repeat (3) takeSample(1'b0);
  endtask

  task automatic t_reset();
    check("R1", debLevel, 1'b0, "debLevel in reset");
    check("R1", pressPulse, 1'b0, "pressPulse in reset");
    @(negedge clk) rstN = 1'b1;
  endtask

  task automatic t_pressHoldRelease();
    @(negedge clk) rawBtn = 1'b1;
    repeat (40) @(negedge clk);
    check("R2", debLevel, 1'b0, "no ticks, button high");
    repeat (14) doTick();
    check("R2", debLevel, 1'b0, "after 14 ticks only two samples");
    doTick();
    check("R4", debLevel, 1'b1, "third high sample");
    check("R4", pressPulse, 1'b1, "press pulse with third sample");
    @(negedge clk);
    check("R6", pressPulse, 1'b0, "pulse one cycle only");
    repeat (2) begin
      takeSample(1'b1);
      check("R6", pressPulse, 1'b0, "no repeat while held");
    end
    takeSample(1'b0);
    takeSample(1'b0);
    check("R7", debLevel, 1'b1, "two low samples keep level");
    takeSample(1'b1);
    check("R8", debLevel, 1'b1, "bounce during release");
    takeSample(1'b0);
    takeSample(1'b0);
    check("R8", debLevel, 1'b1, "release count restarted");
    takeSample(1'b0);
    check("R7", debLevel, 1'b0, "third low sample releases");
    check("R7", pressPulse, 1'b0, "no pulse on release");
  endtask

  task automatic t_idle();
    repeat (3) takeSample(1'b0);
    check("R3", debLevel, 1'b0, "idle low samples");
    check("R3", pressPulse, 1'b0, "idle no pulse");
  endtask

  task automatic t_bounce();
    takeSample(1'b1);
    takeSample(1'b1);
    takeSample(1'b0);
    check("R5", debLevel, 1'b0, "high high low");
    check("R5", pressPulse, 1'b0, "no pulse on aborted press");
    takeSample(1'b1);
    takeSample(1'b1);
    check("R5", debLevel, 1'b0, "press count restarted");
    takeSample(1'b1);
    check("R4", debLevel, 1'b1, "press after restart");
    check("R4", pressPulse, 1'b1, "pulse after restart");
    releaseFully();
    check("R7", debLevel, 1'b0, "released after bounce test");
  endtask

  task automatic t_glitch();
    repeat (3) begin
      @(negedge clk) rawBtn = 1'b1;
      repeat (4) doTick();
      @(negedge clk) rawBtn = 1'b0;
      repeat (3) @(negedge clk);
      doTick();
    end
    check("R2", debLevel, 1'b0, "pulses between samples ignored");
    check("R2", pressPulse, 1'b0, "no pulse from between-sample pulses");
  endtask

  task automatic t_sync();
    @(negedge clk) rawBtn = 1'b0;
    repeat (3) @(negedge clk);
    repeat (4) doTick();
    @(negedge clk);
    rawBtn = 1'b1;
    tickIn = 1'b1;
    @(negedge clk) tickIn = 1'b0;
    check("R9", debLevel, 1'b0, "change on sampling edge unseen");
    takeSample(1'b1);
    takeSample(1'b1);
    check("R9", debLevel, 1'b0, "only two seen high samples");
    takeSample(1'b1);
    check("R9", debLevel, 1'b1, "third seen high sample");
    releaseFully();
  endtask

  task automatic t_midReset();
    takeSample(1'b1);
    takeSample(1'b1);
    takeSample(1'b1);
    check("R4", debLevel, 1'b1, "pressed before reset");
    repeat (2) doTick();
    @(negedge clk) rstN = 1'b0;
    @(negedge clk);
    check("R1", debLevel, 1'b0, "reset clears level");
    @(negedge clk) rstN = 1'b1;
    repeat (3) @(negedge clk);
    repeat (14) doTick();
    check("R1", debLevel, 1'b0, "divider restarted, 14 ticks");
    doTick();
    check("R1", debLevel, 1'b1, "divider restarted, 15 ticks");
    releaseFully();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_pressHoldRelease();
    t_idle();
    t_bounce();
    t_glitch();
    t_sync();
    t_midReset();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nCompared++;
      nMismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
      $finish;
    end
  end

endmodule